// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This block is a purely combinational 32-bit integer unit for the execute stage of a load/store RISC pipeline. It takes two operands and a 4-bit operation code. In the same cycle it returns a result word, a flag that is high when the result is all zeros, and a signed-overflow flag. The operations are four bitwise functions (AND, OR, XOR, NOR), addition, subtraction, and two compare-style operations. The compare operations write 1 or 0 into bit 0 of the result, depending on whether the first operand is less than the second, read either as two's-complement or as unsigned numbers.

A single adder serves every arithmetic operation. For subtraction and both comparisons, the second operand is inverted and the carry into bit 0 is forced high. The adder is a chain of 4-bit lookahead groups. Within each group the carries come from per-bit generate and propagate terms, and only the group carry-out travels on to the next group. The signed comparison and the overflow flag are both taken from the most significant position of that shared adder.

Top module: `int_alu`

## Requirements
- R1: Code 0000 gives opa AND opb, 0001 gives opa OR opb, 1001 gives opa XOR opb, and 1100 gives NOR (the inverse of opa OR opb), each bit by bit.
- R2: Code 0010 gives (opa + opb) modulo 2^32, and carries ripple correctly across every 4-bit group boundary.
- R3: Code 0110 gives (opa - opb) modulo 2^32.
- R4: For codes 0010 and 0110, ovf is 1 exactly when the two's-complement result of the operation does not fit in 32 bits.
- R5: For every code other than 0010 and 0110, ovf is 0, including comparisons whose internal difference overflows.
- R6: Code 0111 sets result bit 0 to 1 when opa < opb as signed numbers, and to 0 otherwise. This holds even when opa - opb overflows. Bits 31..1 are 0.
- R7: Code 1000 sets result bit 0 to 1 when opa < opb as unsigned numbers, and to 0 otherwise. Bits 31..1 are 0.
- R8: zero is 1 exactly when all 32 result bits are 0, for every code.
- R9: Any code not listed in R1 to R7 gives a result of 0 (so zero is 1) and ovf 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| op | input | 4 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| ovf | output | 1 | Signed overflow of ADD or SUB |

## Verification
The hardest case to reach is a signed comparison whose internal difference overflows. In that case the sign bit of the difference gives the wrong answer, and the result depends on the overflow correction alone. The stimulus reaches it with operand pairs of opposite sign at the extremes of the range, such as the most negative value against 1 and the most positive value against -1. The same pairs are also applied as SUB, where ovf must rise, and as the comparison, where ovf must stay low. A second hard case is a carry that ripples through all eight lookahead groups at once. This is reached with all-ones plus one, which also drives the zero flag.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int DATA_W  = 32;
  localparam int GROUP_W = 4;

  typedef enum logic [3:0] {
    OP_AND  = 4'b0000,
    OP_OR   = 4'b0001,
    OP_ADD  = 4'b0010,
    OP_SUB  = 4'b0110,
    OP_SLT  = 4'b0111,
    OP_SLTU = 4'b1000,
    OP_XOR  = 4'b1001,
    OP_NOR  = 4'b1100
  } alu_op_e;

  // True when the operation needs the adder in subtract mode
  function automatic logic needs_invert(input logic [3:0] code);
    return (code == OP_SUB) || (code == OP_SLT) || (code == OP_SLTU);
  endfunction
endpackage

// File: rtl/cla_group.sv
module cla_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] prop;
  logic [W-1:0] gen;
  logic [W:0]   carry;

  assign prop     = a | b;
  assign gen      = a & b;
  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign carry[i+1] = gen[i] | (prop[i] & carry[i]);
  end

  assign sum  = a ^ b ^ carry[W-1:0];
  assign cout = carry[W];
endmodule

// File: rtl/cla_chain.sv
module cla_chain #(
  parameter int WIDTH   = 32,
  parameter int GROUP_W = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             msb_cin
);
  localparam int NGROUP = WIDTH / GROUP_W;

  logic [NGROUP:0] gcarry;
  assign gcarry[0] = cin;

  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    cla_group #(.W(GROUP_W)) grp_i (
      .a   (a[g*GROUP_W +: GROUP_W]),
      .b   (b[g*GROUP_W +: GROUP_W]),
      .cin (gcarry[g]),
      .sum (sum[g*GROUP_W +: GROUP_W]),
      .cout(gcarry[g+1])
    );
  end

  assign cout    = gcarry[NGROUP];
  // carry into the top bit recovered from its sum and operand bits
  assign msb_cin = sum[WIDTH-1] ^ a[WIDTH-1] ^ b[WIDTH-1];
endmodule

// File: rtl/bitwise_unit.sv
module bitwise_unit #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] xor_o,
  output logic [WIDTH-1:0] nor_o
);
  assign and_o = a & b;
  assign or_o  = a | b;
  assign xor_o = a ^ b;
  assign nor_o = ~(a | b);
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH   = DATA_W,
  parameter int GROUP_W = int_alu_pkg::GROUP_W
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [3:0]       op,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  // reference arithmetic for the guards, written apart from the adder
  function automatic logic [WIDTH-1:0] ref_add(input logic [WIDTH-1:0] x, y);
    return x + y;
  endfunction
  function automatic logic [WIDTH-1:0] ref_sub(input logic [WIDTH-1:0] x, y);
    return x - y;
  endfunction

  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  // named internal events
  logic             sub_mode;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] add_sum;
  logic             add_cout;
  logic             add_msb_cin;
  logic             raw_ovf;
  logic             less_signed;
  logic             less_unsigned;
  logic [WIDTH-1:0] and_v, or_v, xor_v, nor_v;

  assign sub_mode = needs_invert(op);
  assign b_eff    = opb ^ {WIDTH{sub_mode}};

  cla_chain #(.WIDTH(WIDTH), .GROUP_W(GROUP_W)) adder_i (
    .a      (opa),
    .b      (b_eff),
    .cin    (sub_mode),
    .sum    (add_sum),
    .cout   (add_cout),
    .msb_cin(add_msb_cin)
  );

  bitwise_unit #(.WIDTH(WIDTH)) logic_i (
    .a    (opa),
    .b    (opb),
    .and_o(and_v),
    .or_o (or_v),
    .xor_o(xor_v),
    .nor_o(nor_v)
  );

  assign raw_ovf       = add_msb_cin ^ add_cout;
  assign less_signed   = add_sum[MSB] ^ raw_ovf;
  assign less_unsigned = ~add_cout;

  always_comb begin
    result = '0;
    ovf    = 1'b0;
    case (op_e)
      OP_AND:  result = and_v;
      OP_OR:   result = or_v;
      OP_XOR:  result = xor_v;
      OP_NOR:  result = nor_v;
      OP_ADD:  begin result = add_sum; ovf = raw_ovf; end
      OP_SUB:  begin result = add_sum; ovf = raw_ovf; end
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, less_signed};
      OP_SLTU: result = {{(WIDTH-1){1'b0}}, less_unsigned};
      default: result = '0;
    endcase
  end

  assign zero = ~|result;

  // guards next to the logic
  always_comb begin
    if (op == OP_ADD) begin
      p_add_sum_r2: assert (result == ref_add(opa, opb));
      p_add_ovf_r4: assert (ovf == ((opa[MSB] == opb[MSB]) && (result[MSB] != opa[MSB])));
    end
    if (op == OP_SUB) begin
      p_sub_diff_r3: assert (result == ref_sub(opa, opb));
    end
    if (op != OP_ADD && op != OP_SUB) begin
      p_no_overflow_r5: assert (!ovf);
    end
    if (op == OP_SLT) begin
      p_slt_signed_r6: assert (result[0] == ($signed(opa) < $signed(opb)) && result[MSB:1] == '0);
    end
    if (op == OP_SLTU) begin
      p_sltu_unsigned_r7: assert (result[0] == (opa < opb) && result[MSB:1] == '0);
    end
  end
endmodule

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic [31:0] opa, opb;
  logic [3:0]  op;
  logic [31:0] result;
  logic        zero, ovf;

  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu dut_i (
    .opa(opa), .opb(opb), .op(op),
    .result(result), .zero(zero), .ovf(ovf)
  );

  // expected behaviour restated from the requirements
  function automatic void model(input logic [3:0] c, input logic [31:0] a, b,
                                output logic [31:0] r, output logic v);
    v = 1'b0;
    case (c)
      4'b0000: r = a & b;
      4'b0001: r = a | b;
      4'b1001: r = a ^ b;
      4'b1100: r = ~(a | b);
      4'b0010: begin r = a + b; v = (a[31] == b[31]) && (r[31] != a[31]); end
      4'b0110: begin r = a - b; v = (a[31] != b[31]) && (r[31] != a[31]); end
      4'b0111: r = {31'd0, ($signed(a) < $signed(b))};
      4'b1000: r = {31'd0, (a < b)};
      default: r = 32'd0;
    endcase
  endfunction

  task automatic apply_check(input string tag, input logic [3:0] c,
                             input logic [31:0] a, b);
    logic [31:0] er;
    logic ev;
    @(negedge clk);
    op = c; opa = a; opb = b;
    #1;
    model(c, a, b, er, ev);
    tests_run++;
    if (result !== er || zero !== (er == 32'd0) || ovf !== ev) begin
      tests_failed++;
      $display("FAIL %s op=%b a=%h b=%h: got r=%h z=%b v=%b, want r=%h z=%b v=%b",
               tag, c, a, b, result, zero, ovf, er, (er == 32'd0), ev);
    end
  endtask

  task automatic t_idle();
    apply_check("R8 idle zeros", 4'b0000, 32'd0, 32'd0);
  endtask

  task automatic t_logic();
    apply_check("R1 and", 4'b0000, 32'hF0F0_A5A5, 32'hFF00_0FF0);
    apply_check("R1 or",  4'b0001, 32'hF0F0_A5A5, 32'h0F00_0FF0);
    apply_check("R1 xor", 4'b1001, 32'hDEAD_BEEF, 32'hFFFF_0000);
    apply_check("R1 nor", 4'b1100, 32'h1234_5678, 32'h0000_FFFF);
    apply_check("R8 nor all ones", 4'b1100, 32'hFFFF_FFFF, 32'd0);
  endtask

  task automatic t_add();
    apply_check("R2 add basic", 4'b0010, 32'd1234, 32'd4321);
    apply_check("R2 add group carry", 4'b0010, 32'h0000_000F, 32'd1);
    apply_check("R2 R8 add full ripple", 4'b0010, 32'hFFFF_FFFF, 32'd1);
    apply_check("R4 add pos ovf", 4'b0010, 32'h7FFF_FFFF, 32'd1);
    apply_check("R4 add neg ovf", 4'b0010, 32'h8000_0000, 32'h8000_0000);
  endtask

  task automatic t_sub();
    apply_check("R3 sub neg", 4'b0110, 32'd5, 32'd7);
    apply_check("R3 R8 sub equal", 4'b0110, 32'hCAFE_0001, 32'hCAFE_0001);
    apply_check("R4 sub ovf", 4'b0110, 32'h8000_0000, 32'd1);
    apply_check("R4 sub ovf pos", 4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic t_compare();
    apply_check("R6 slt neg<pos", 4'b0111, 32'hFFFF_FFFE, 32'd3);
    apply_check("R6 slt pos>neg", 4'b0111, 32'd3, 32'hFFFF_FFFE);
    apply_check("R6 R5 slt ovf min<1", 4'b0111, 32'h8000_0000, 32'd1);
    apply_check("R6 R5 slt ovf max>-1", 4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    apply_check("R6 slt equal", 4'b0111, 32'd9, 32'd9);
    apply_check("R7 sltu big>small", 4'b1000, 32'hFFFF_FFFE, 32'd3);
    apply_check("R7 sltu small<big", 4'b1000, 32'd3, 32'hFFFF_FFFE);
    apply_check("R7 sltu equal", 4'b1000, 32'd0, 32'd0);
  endtask

  task automatic t_undefined();
    apply_check("R9 code 0011", 4'b0011, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
    apply_check("R9 code 1111", 4'b1111, 32'h8000_0000, 32'h8000_0000);
    apply_check("R9 code 0101", 4'b0101, 32'h1234_5678, 32'h9ABC_DEF0);
  endtask

  task automatic t_sweep();
    logic [31:0] x = 32'h1357_9BDF;
    logic [31:0] y = 32'hACE0_2468;
    logic [3:0] codes [8] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110,
                              4'b0111, 4'b1000, 4'b1001, 4'b1100};
    for (int i = 0; i < 24; i++) begin
      x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
      y = {y[30:0], y[31] ^ y[21] ^ y[1] ^ y[0]} + 32'h0101_0101;
      apply_check("R1 R2 R3 R6 R7 sweep", codes[i % 8], x, y);
    end
  endtask

  initial begin
    op = 4'b0000; opa = '0; opb = '0;
    t_idle();
    t_logic();
    t_add();
    t_sub();
    t_compare();
    t_undefined();
    t_sweep();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog expired: got no end, want completion");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule